// File: doc/BRIEF.md
# Branch Target Cache with Direction Predictor

This block sits beside the fetch stage of an in-order core. Every cycle it looks up the current fetch address. If it finds a matching entry, it returns three things: a hit, a take/not-take decision and a stored destination address. The fetch unit can then steer the next fetch to that destination without a bubble. Each entry records the kind of control transfer it describes: a conditional branch, an unconditional jump or a subroutine return. Jumps and returns are always predicted taken. Conditional branches are predicted by a 2-bit saturating counter held in the entry.

The execute stage reports each resolved control transfer on an update port. The report carries its address, its kind, whether it was taken and its real destination. An update that finds no matching entry allocates one, replacing whatever occupied that slot. An update that matches an entry trains the counter and rewrites a stale destination. This is how a return that was reached from a new call site gets corrected.

An instruction-fence flush input invalidates the whole cache in one cycle. An optional parity bit per entry turns a corrupted read into a plain miss, so a damaged entry never steers fetch.

Top module: `btc_predictor`

## Requirements
- R1: While the synchronous reset `rst` is high, every entry is invalidated, so no lookup hits in the cycles that follow until an update allocates an entry.
- R2: An accepted update (`upd_valid` high, `flush` low) whose address has no matching entry writes a new entry. From the next cycle on, a lookup of that exact address hits and returns `upd_target`. The slot is selected by address bits [IDX_W+1:2] and the tag is the bits above them. A match requires the tag and the kind to agree.
- R3: Kind codes are 2'b00 conditional branch, 2'b01 jump and 2'b10 return. A hit on a jump or return entry always reports taken, and `pred_kind` reports the stored code.
- R4: A newly written conditional-branch entry starts its counter at 2'b10 if the update was taken and at 2'b01 if it was not. A conditional hit predicts taken exactly when counter bit 1 is set.
- R5: An update that matches a conditional entry moves its counter one step: up when taken, saturating at 2'b11, and down when not taken, saturating at 2'b00.
- R6: A taken update that matches an entry replaces the stored destination with `upd_target`, which corrects a mispredicted return target. A not-taken update keeps the old destination.
- R7: An update whose tag or kind differs from the entry in its slot overwrites that entry. After that, the previous address misses.
- R8: A `flush` pulse invalidates every entry in one cycle. An update presented in the same cycle is discarded.
- R9: A lookup and an update in the same cycle to the same slot: the lookup returns the contents from before the update.
- R10: On a miss, `pred_hit`, `pred_taken`, `pred_kind` and `pred_target` are all zero. With parity enabled, a parity mismatch on the fetched entry forces this miss result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Instruction-fence invalidate-all pulse |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_hit | output | 1 | Valid matching entry with clean parity |
| pred_taken | output | 1 | Redirect fetch to `pred_target` |
| pred_kind | output | 2 | Kind code of the hit entry |
| pred_target | output | PC_W | Stored destination of the hit entry |
| upd_valid | input | 1 | Resolved control transfer present |
| upd_pc | input | PC_W | Address of the resolved instruction |
| upd_kind | input | 2 | Kind code of the resolved instruction |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | PC_W | Resolved destination |

## Verification
The bench builds the block with a 16-bit address, 16 entries and parity enabled. With so few slots, two addresses that differ only in bit 10 share a slot, so the bench can exercise tag replacement and kind replacement without long address sweeps. Parity is enabled so that clean parity is checked on every hit. The bench overrides the parity comparison result for single lookups to confirm that an error suppresses the prediction. A long random phase mixes all three kinds, flushes and same-slot collisions.

// File: rtl/btc_pkg.sv
package btc_pkg;

  typedef enum logic [1:0] {
    KIND_COND = 2'b00,
    KIND_JUMP = 2'b01,
    KIND_RET  = 2'b10
  } kind_e;

  localparam logic [1:0] CTR_WEAK_TAKEN     = 2'b10;
  localparam logic [1:0] CTR_WEAK_NOT_TAKEN = 2'b01;

  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    if (taken) nxt = (cur == 2'b11) ? cur : cur + 2'd1;
    else       nxt = (cur == 2'b00) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/btc_store.sv
module btc_store #(
  parameter int  DEPTH     = 1024,
  parameter int  WIDTH     = 64,
  parameter bit  PARITY_EN = 1'b1,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  output logic             rpar_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b,
  output logic             rpar_b
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  generate
    if (PARITY_EN) begin : g_par
      logic par_mem [DEPTH];
      always_ff @(posedge clk) begin
        if (we) par_mem[waddr] <= ^wdata;
      end
      assign rpar_a = par_mem[raddr_a];
      assign rpar_b = par_mem[raddr_b];
    end else begin : g_nopar
      assign rpar_a = 1'b0;
      assign rpar_b = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/btc_valid.sv
module btc_valid #(
  parameter int  DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          set,
  input  logic [AW-1:0] set_idx,
  input  logic [AW-1:0] idx_a,
  output logic          vld_a,
  input  logic [AW-1:0] idx_b,
  output logic          vld_b
);

  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
    end else if (set) begin
      vld_q[set_idx] <= 1'b1;
    end
  end

  assign vld_a = vld_q[idx_a];
  assign vld_b = vld_q[idx_b];

endmodule

// File: rtl/btc_update.sv
module btc_update
  import btc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            match,
  input  logic [1:0]      upd_kind,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic [1:0]      old_ctr,
  input  logic [PC_W-1:0] old_target,
  output logic [1:0]      new_ctr,
  output logic [PC_W-1:0] new_target
);

  always_comb begin
    if (match && upd_kind == KIND_COND) begin
      new_ctr = ctr_step(old_ctr, upd_taken);
    end else begin
      new_ctr = upd_taken ? CTR_WEAK_TAKEN : CTR_WEAK_NOT_TAKEN;
    end

    if (match && !upd_taken) new_target = old_target;
    else                     new_target = upd_target;
  end

endmodule

// File: rtl/btc_predictor.sv
module btc_predictor
  import btc_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int ENTRIES   = 1024,
  parameter bit PARITY_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [1:0]      pred_kind,
  output logic [PC_W-1:0] pred_target,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [1:0]      upd_kind,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - 2;
  localparam int ENT_W = TAG_W + 4 + PC_W;
  localparam int CTR_LO  = PC_W;
  localparam int KIND_LO = PC_W + 2;
  localparam int TAG_LO  = PC_W + 4;

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic [ENT_W-1:0] f_ent, u_ent, w_ent;
  logic             f_par, u_par;
  logic             f_vld, u_vld;
  logic             fetch_par_ok, upd_par_ok;
  logic             f_hit, u_match;
  logic             wr_en;
  logic [1:0]       new_ctr;
  logic [PC_W-1:0]  new_target;

  assign f_idx = fetch_pc[IDX_W+1:2];
  assign f_tag = fetch_pc[PC_W-1:IDX_W+2];
  assign u_idx = upd_pc[IDX_W+1:2];
  assign u_tag = upd_pc[PC_W-1:IDX_W+2];

  assign wr_en = upd_valid && !flush && !rst;

  btc_store #(
    .DEPTH(ENTRIES), .WIDTH(ENT_W), .PARITY_EN(PARITY_EN)
  ) u_store (
    .clk(clk), .we(wr_en), .waddr(u_idx), .wdata(w_ent),
    .raddr_a(f_idx), .rdata_a(f_ent), .rpar_a(f_par),
    .raddr_b(u_idx), .rdata_b(u_ent), .rpar_b(u_par)
  );

  btc_valid #(.DEPTH(ENTRIES)) u_valid (
    .clk(clk), .rst(rst), .flush(flush),
    .set(wr_en), .set_idx(u_idx),
    .idx_a(f_idx), .vld_a(f_vld),
    .idx_b(u_idx), .vld_b(u_vld)
  );

  generate
    if (PARITY_EN) begin : g_chk
      assign fetch_par_ok = ((^f_ent) == f_par);
      assign upd_par_ok   = ((^u_ent) == u_par);
    end else begin : g_nochk
      assign fetch_par_ok = 1'b1;
      assign upd_par_ok   = 1'b1;
    end
  endgenerate

  // Lookup path
  assign f_hit = f_vld && (f_ent[ENT_W-1:TAG_LO] == f_tag) && fetch_par_ok;

  always_comb begin
    pred_hit    = f_hit;
    pred_kind   = 2'b00;
    pred_target = '0;
    pred_taken  = 1'b0;
    if (f_hit) begin
      pred_kind   = f_ent[KIND_LO+1:KIND_LO];
      pred_target = f_ent[PC_W-1:0];
      pred_taken  = (pred_kind != KIND_COND) || f_ent[CTR_LO+1];
    end
  end

  // Update path
  assign u_match = u_vld && upd_par_ok &&
                   (u_ent[ENT_W-1:TAG_LO] == u_tag) &&
                   (u_ent[KIND_LO+1:KIND_LO] == upd_kind);

  btc_update #(.PC_W(PC_W)) u_upd (
    .match(u_match), .upd_kind(upd_kind), .upd_taken(upd_taken),
    .upd_target(upd_target),
    .old_ctr(u_ent[CTR_LO+1:CTR_LO]), .old_target(u_ent[PC_W-1:0]),
    .new_ctr(new_ctr), .new_target(new_target)
  );

  assign w_ent = {u_tag, upd_kind, new_ctr, new_target};

endmodule

// File: rtl/btc_predictor_chk.sv
module btc_predictor_chk
  import btc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_hit,
  input logic            pred_taken,
  input logic [1:0]      pred_kind,
  input logic [PC_W-1:0] pred_target,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !pred_hit);

  assert_taken_update_visible_R2: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !flush && upd_taken) |=>
      ((fetch_pc != $past(upd_pc)) || (pred_hit && pred_target == $past(upd_target))));

  assert_uncond_taken_R3: assert property (@(posedge clk) disable iff (rst)
    (pred_hit && pred_kind != KIND_COND) |-> pred_taken);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pred_hit);

  assert_miss_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> (!pred_taken && pred_kind == 2'b00 && pred_target == '0));

endmodule

bind btc_predictor btc_predictor_chk #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rst(rst), .flush(flush), .fetch_pc(fetch_pc),
  .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_kind(pred_kind),
  .pred_target(pred_target), .upd_valid(upd_valid), .upd_pc(upd_pc),
  .upd_taken(upd_taken), .upd_target(upd_target)
);

// File: tb/btc_predictor_tb.sv
module btc_predictor_tb_top;

  localparam int PC_W = 16;
  localparam int N    = 16;

  logic            clk = 1'b0;
  logic            rst, flush;
  logic [PC_W-1:0] fetch_pc;
  logic            pred_hit, pred_taken;
  logic [1:0]      pred_kind;
  logic [PC_W-1:0] pred_target;
  logic            upd_valid, upd_taken;
  logic [PC_W-1:0] upd_pc, upd_target;
  logic [1:0]      upd_kind;

  int errors = 0;
  int checks = 0;
  bit par_fault = 1'b0;

  always #2.5 clk = ~clk;

  btc_predictor #(.PC_W(PC_W), .ENTRIES(N), .PARITY_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .flush(flush), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_kind(pred_kind),
    .pred_target(pred_target), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_kind(upd_kind), .upd_taken(upd_taken), .upd_target(upd_target)
  );

  // Behavioural reference: one record per slot
  bit              m_vld [N];
  int              m_tag [N];
  int              m_kind[N];
  int              m_ctr [N];
  int              m_tgt [N];

  function automatic int slot(input logic [PC_W-1:0] pc);
    return int'(pc[5:2]);
  endfunction
  function automatic int tagof(input logic [PC_W-1:0] pc);
    return int'(pc[15:6]);
  endfunction

  task automatic check_lookup(input string req);
    int  s;
    bit  e_hit, e_taken;
    int  e_kind, e_tgt;
    s = slot(fetch_pc);
    e_hit = m_vld[s] && m_tag[s] == tagof(fetch_pc) && !par_fault;
    e_kind = e_hit ? m_kind[s] : 0;
    e_tgt  = e_hit ? m_tgt[s] : 0;
    e_taken = e_hit && (m_kind[s] != 0 || m_ctr[s] >= 2);
    checks++;
    if (pred_hit !== e_hit || pred_taken !== e_taken ||
        int'(pred_kind) != e_kind || int'(pred_target) != e_tgt) begin
      errors++;
      $display("FAIL %s pc=%h actual hit=%0b tk=%0b kind=%0d tgt=%h expected hit=%0b tk=%0b kind=%0d tgt=%h",
               req, fetch_pc, pred_hit, pred_taken, pred_kind, pred_target,
               e_hit, e_taken, e_kind, e_tgt);
    end
  endtask

  task automatic model_edge();
    int s;
    if (rst || flush) begin
      for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    end else if (upd_valid) begin
      s = slot(upd_pc);
      if (m_vld[s] && m_tag[s] == tagof(upd_pc) && m_kind[s] == int'(upd_kind)) begin
        if (upd_kind == 2'b00) begin
          if (upd_taken) m_ctr[s] = (m_ctr[s] == 3) ? 3 : m_ctr[s] + 1;
          else           m_ctr[s] = (m_ctr[s] == 0) ? 0 : m_ctr[s] - 1;
        end
        if (upd_taken) m_tgt[s] = int'(upd_target);
      end else begin
        m_vld[s]  = 1'b1;
        m_tag[s]  = tagof(upd_pc);
        m_kind[s] = int'(upd_kind);
        m_ctr[s]  = upd_taken ? 2 : 1;
        m_tgt[s]  = int'(upd_target);
      end
    end
  endtask

  // One clock: drive after falling edge, check lookup before rising edge
  task automatic cyc(input logic [PC_W-1:0] fpc, input bit uv,
                     input logic [PC_W-1:0] upc, input logic [1:0] uk,
                     input bit ut, input logic [PC_W-1:0] utg,
                     input bit fl, input string req);
    fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_kind = uk;
    upd_taken = ut; upd_target = utg; flush = fl;
    #1;
    if (!rst) check_lookup(req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic look(input logic [PC_W-1:0] fpc, input string req);
    cyc(fpc, 1'b0, '0, 2'b00, 1'b0, '0, 1'b0, req);
  endtask

  task automatic upd(input logic [PC_W-1:0] upc, input logic [1:0] uk,
                     input bit ut, input logic [PC_W-1:0] utg, input string req);
    cyc(upc, 1'b1, upc, uk, ut, utg, 1'b0, req);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; flush = 1'b0; fetch_pc = '0; upd_valid = 1'b0;
    upd_pc = '0; upd_kind = 2'b00; upd_taken = 1'b0; upd_target = '0;
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    repeat (3) @(posedge clk);
    model_edge();
    @(negedge clk);
    rst = 1'b0;

    // R1: nothing hits after reset
    look(16'h0100, "R1");
    look(16'h0040, "R1");

    // R9 lookup during allocation sees old (empty) slot; R2/R4 after
    upd(16'h0040, 2'b00, 1'b1, 16'h0200, "R9");
    look(16'h0040, "R2 R4");

    // R5 training down, R6 target kept on not taken
    upd(16'h0040, 2'b00, 1'b0, 16'h0044, "R5");
    look(16'h0040, "R5 R6");
    upd(16'h0040, 2'b00, 1'b0, 16'h0044, "R5");
    upd(16'h0040, 2'b00, 1'b0, 16'h0044, "R5");
    look(16'h0040, "R5");
    // R5 training up to saturation
    for (int i = 0; i < 5; i++) upd(16'h0040, 2'b00, 1'b1, 16'h0210, "R5");
    look(16'h0040, "R5 R6");
    upd(16'h0040, 2'b00, 1'b0, 16'h0044, "R5");
    look(16'h0040, "R5");

    // R4 new not-taken conditional starts weakly not taken
    upd(16'h0044, 2'b00, 1'b0, 16'h0048, "R4");
    look(16'h0044, "R4");

    // R3 jump and return predicted taken
    upd(16'h0048, 2'b01, 1'b1, 16'h0300, "R3");
    look(16'h0048, "R3");
    upd(16'h004C, 2'b10, 1'b1, 16'h0400, "R3");
    look(16'h004C, "R3");
    // R6 return target corrected
    upd(16'h004C, 2'b10, 1'b1, 16'h0480, "R6");
    look(16'h004C, "R6");

    // R7 tag conflict in same slot, then kind change
    upd(16'h0440, 2'b01, 1'b1, 16'h0500, "R7");
    look(16'h0040, "R7");
    look(16'h0440, "R7");
    upd(16'h0048, 2'b00, 1'b0, 16'h004C, "R7");
    look(16'h0048, "R7");

    // R10 parity error suppresses prediction
    fetch_pc = 16'h004C;
    force dut_i.fetch_par_ok = 1'b0;
    par_fault = 1'b1;
    look(16'h004C, "R10");
    release dut_i.fetch_par_ok;
    par_fault = 1'b0;
    look(16'h004C, "R10");
    look(16'h0070, "R10");

    // R8 flush with concurrent update
    cyc(16'h0050, 1'b1, 16'h0050, 2'b01, 1'b1, 16'h0600, 1'b1, "R8");
    look(16'h0050, "R8");
    look(16'h004C, "R8");
    look(16'h0440, "R8");

    // Mixed random traffic against the reference (R2 R5 R6 R7 R8 R9)
    for (int i = 0; i < 400; i++) begin
      logic [PC_W-1:0] p, f, t;
      logic [1:0] k;
      bit tk, v, fl;
      p  = 16'h0040 + 16'(($urandom % 8) * 4) + (($urandom % 2) != 0 ? 16'h0400 : 16'h0000);
      f  = ($urandom % 2) != 0 ? p : 16'h0040 + 16'(($urandom % 8) * 4);
      k  = 2'(($urandom % 3));
      tk = (k != 2'b00) ? 1'b1 : bit'($urandom % 2);
      t  = 16'(($urandom % 4096) * 4);
      v  = ($urandom % 4) != 0;
      fl = ($urandom % 40) == 0;
      cyc(f, v, p, k, tk, t, fl, "R2");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule